// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Controller

This peripheral produces up to eight independent pulse-width modulated outputs behind a small word-addressed register bus. A single gate register turns channels on and off, one bit per channel. Each channel has its own bank of registers. The bank holds a power-of-two clock prescale exponent, a 13-bit period count and a 13-bit high-time threshold. Both counts are written as the wanted number of ticks minus one.

Software programs a bank and then sets the channel's gate bit. The output starts a new cycle high on the next clock. Values written while a channel runs are held in the bank and copied into the running counter logic only when the current period ends. A waveform is therefore never cut short or stretched by a reconfiguration. Reads are combinational from the address. Writes take effect on the rising clock edge while the write enable is high.

Top module: `pwm_multi_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every register and counter. While reset is applied and after it is released, all outputs are low and every register reads zero.
- R2: The gate register sits at byte offset 0x00. Bit n enables channel n. Bits at and above NUM_CH ignore writes and read as zero.
- R3: Channel n's bank starts at byte offset 0x10 + n*0x40. Within a bank, the period register is at +0x2C and the threshold register is at +0x30. Each holds bits [12:0] and reads every other bit as zero.
- R4: The control register is at bank offset +0x00. Bits [2:0] hold the prescale exponent k. Bit 15 is a plain read/write flag. All other bits read as zero.
- R5: With period value W and exponent k, the output period lasts (W+1)*2^k clock cycles.
- R6: With threshold T < W, the output is high for the first (T+1)*2^k clock cycles of each period and low for the rest.
- R7: When T >= W, the output stays high for the whole period without a low cycle.
- R8: A channel whose gate bit is clear drives its output low. Setting the bit makes the output high from the first clock edge after the write, at the start of a fresh period.
- R9: Changes to period, threshold or exponent written while a channel runs leave the current period unchanged. They take effect from the next period boundary.
- R10: Reads of unmapped offsets return zero, and writes to them change nothing. This includes the gap 0x04 to 0x0F, unused bank offsets, and banks of channels at or above NUM_CH.
- R11: Channels count independently. Disabling or reprogramming one channel does not disturb another channel's waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One PWM waveform per channel |

## Verification
The bench builds the block with NUM_CH = 3, a 12-bit address and 32-bit data. This leaves gate bits 3 to 7 and the whole fourth bank slot unimplemented, so the masking and write-ignore rules of R2 and R10 can be exercised at real addresses. The three live channels run with exponents 0, 1, 2 and 7 and with thresholds below, equal to and above the period. The bench also rewrites period and threshold in the cycle a period begins, which puts the shadow boundary of R9 within reach sample by sample.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Counter and field widths
    localparam int CNT_W     = 13;
    localparam int PRE_W     = 3;
    localparam int PRE_CNT_W = (1 << PRE_W) - 1;
    localparam int MARK_BIT  = 15;
    localparam int CH_IDX_W  = 3;

    // Address map (byte offsets)
    localparam int              DEC_AW      = 16;
    localparam logic [DEC_AW-1:0] GATE_OFS  = 16'h0000;
    localparam logic [DEC_AW-1:0] BANK_BASE = 16'h0010;
    localparam int              BANK_SHIFT  = 6;
    localparam logic [BANK_SHIFT-1:0] CTRL_OFS   = 6'h00;
    localparam logic [BANK_SHIFT-1:0] PERIOD_OFS = 6'h2C;
    localparam logic [BANK_SHIFT-1:0] DUTY_OFS   = 6'h30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GATE,
        SEL_CTRL,
        SEL_PERIOD,
        SEL_DUTY
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e              sel;
        logic [CH_IDX_W-1:0]   ch;
    } reg_hit_t;

    // Settings that drive a running channel
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
    } run_cfg_t;

    // Map a byte address onto a register selector and channel index
    function automatic reg_hit_t decode_addr(input logic [DEC_AW-1:0] addr,
                                             input int num_ch);
        reg_hit_t          h;
        logic [DEC_AW-1:0] rel;
        logic [DEC_AW-1:0] bank;
        h.sel = SEL_NONE;
        h.ch  = '0;
        rel   = '0;
        bank  = '0;
        if (addr == GATE_OFS) begin
            h.sel = SEL_GATE;
        end else if (addr >= BANK_BASE) begin
            rel  = addr - BANK_BASE;
            bank = rel >> BANK_SHIFT;
            if (int'(bank) < num_ch) begin
                h.ch = bank[CH_IDX_W-1:0];
                case (rel[BANK_SHIFT-1:0])
                    CTRL_OFS:   h.sel = SEL_CTRL;
                    PERIOD_OFS: h.sel = SEL_PERIOD;
                    DUTY_OFS:   h.sel = SEL_DUTY;
                    default:    h.sel = SEL_NONE;
                endcase
            end
        end
        return h;
    endfunction

    // Terminal value of the prescale counter for exponent k: 2^k - 1
    function automatic logic [PRE_CNT_W-1:0] tick_limit(input logic [PRE_W-1:0] k);
        return ~({PRE_CNT_W{1'b1}} << k);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CH-1:0]        ch_enable,
    output run_cfg_t [NUM_CH-1:0]    ch_cfg
);

    reg_hit_t                 hit;
    logic [NUM_CH-1:0]        gate_q;
    logic [NUM_CH-1:0]        mark_q;
    run_cfg_t [NUM_CH-1:0]    cfg_q;
    run_cfg_t                 sel_cfg;
    logic                     sel_mark;
    logic                     wdata_unused;

    assign hit = decode_addr(DEC_AW'(bus_addr), NUM_CH);

    // Bits of the write data that no field stores
    assign wdata_unused = ^{bus_wdata[DATA_W-1:MARK_BIT+1], bus_wdata[MARK_BIT-1:CNT_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            mark_q <= '0;
            for (int n = 0; n < NUM_CH; n++) begin
                cfg_q[n] <= '0;
            end
        end else if (bus_we) begin
            if (hit.sel == SEL_GATE) begin
                gate_q <= bus_wdata[NUM_CH-1:0];
            end
            for (int n = 0; n < NUM_CH; n++) begin
                if (int'(hit.ch) == n) begin
                    case (hit.sel)
                        SEL_CTRL: begin
                            mark_q[n]    <= bus_wdata[MARK_BIT];
                            cfg_q[n].pre <= bus_wdata[PRE_W-1:0];
                        end
                        SEL_PERIOD: cfg_q[n].period <= bus_wdata[CNT_W-1:0];
                        SEL_DUTY:   cfg_q[n].duty   <= bus_wdata[CNT_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Read path
    always_comb begin
        sel_cfg  = '0;
        sel_mark = 1'b0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (int'(hit.ch) == n) begin
                sel_cfg  = cfg_q[n];
                sel_mark = mark_q[n];
            end
        end
        bus_rdata = '0;
        case (hit.sel)
            SEL_GATE:   bus_rdata[NUM_CH-1:0] = gate_q;
            SEL_CTRL: begin
                bus_rdata[MARK_BIT]  = sel_mark;
                bus_rdata[PRE_W-1:0] = sel_cfg.pre;
            end
            SEL_PERIOD: bus_rdata[CNT_W-1:0] = sel_cfg.period;
            SEL_DUTY:   bus_rdata[CNT_W-1:0] = sel_cfg.duty;
            default: ;
        endcase
    end

    assign ch_enable = gate_q;
    assign ch_cfg    = cfg_q;

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] shift,
    output logic             tick
);

    logic [PRE_CNT_W-1:0] cnt_q;
    logic [PRE_CNT_W-1:0] limit;

    assign limit = tick_limit(shift);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  run_cfg_t cfg,
    output logic     wave
);

    run_cfg_t         act_q;
    logic [CNT_W-1:0] pos_q;
    logic             tick;
    logic             wrap;

    pwm_tick_gen u_tick (
        .clk   (clk),
        .rst   (rst),
        .run   (en),
        .shift (act_q.pre),
        .tick  (tick)
    );

    assign wrap = tick && (pos_q == act_q.period);

    // Active settings follow the bank while idle and at each period boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            pos_q <= '0;
        end else if (!en) begin
            act_q <= cfg;
            pos_q <= '0;
        end else if (wrap) begin
            act_q <= cfg;
            pos_q <= '0;
        end else if (tick) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign wave = en && (pos_q <= act_q.duty);

endmodule

// File: rtl/pwm_multi_ctrl.sv
module pwm_multi_ctrl
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]     ch_enable;
    run_cfg_t [NUM_CH-1:0] ch_cfg;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_enable (ch_enable),
        .ch_cfg    (ch_cfg)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm_channel u_chan (
            .clk  (clk),
            .rst  (rst),
            .en   (ch_enable[n]),
            .cfg  (ch_cfg[n]),
            .wave (pwm_out[n])
        );
    end

endmodule

// File: rtl/pwm_multi_ctrl_chk.sv
module pwm_multi_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] ch_enable
);

    localparam logic [DATA_W-1:0] CTRL_KEEP = DATA_W'(32'h0000_8007);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pwm_out == '0 && ch_enable == '0));

    a_r2_gate_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == '0) |-> ((bus_rdata >> NUM_CH) == '0));

    a_r4_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(16'h0010)) |-> ((bus_rdata & ~CTRL_KEEP) == '0));

    a_r10_gap_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= ADDR_W'(4) && bus_addr < ADDR_W'(16)) |-> (bus_rdata == '0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan_chk
        a_r8_disabled_low: assert property (@(posedge clk) disable iff (rst)
            !ch_enable[n] |-> !pwm_out[n]);

        a_r8_start_high: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_enable[n]) |-> pwm_out[n]);
    end

endmodule

bind pwm_multi_ctrl pwm_multi_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .ch_enable (ch_enable)
);

// File: tb/tb_pwm_multi_ctrl.sv
module tb_pwm_multi_ctrl;

    localparam int NCH = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [11:0]     addr = '0;
    logic            we = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  pwm;

    always #4 clk = ~clk;

    pwm_multi_ctrl #(.NUM_CH(NCH), .ADDR_W(12), .DATA_W(32)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .pwm_out   (pwm)
    );

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        int    ch;
        int    hi;
        int    per;
        string tag;
    } wave_item_t;

    wave_item_t wave_q[$];
    int         pending = 0;
    wave_item_t mon_item;
    int         mon_hi;
    int         mon_per;
    logic [31:0] samp;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        we   = 1'b0;
        #1;
        check(tag, rdata, exp);
    endtask

    // Full period starting at the next rising edge of the channel output
    task automatic measure(input int ch, output int hi, output int per);
        int lo;
        hi = 0;
        lo = 0;
        @(negedge clk);
        while (pwm[ch] !== 1'b0) @(negedge clk);
        while (pwm[ch] !== 1'b1) @(negedge clk);
        while (pwm[ch] === 1'b1) begin hi++; @(negedge clk); end
        while (pwm[ch] === 1'b0) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask

    // Driver side of the scoreboard
    task automatic expect_wave(input int ch, input int hi, input int per, input string tag);
        wave_item_t it;
        it.ch  = ch;
        it.hi  = hi;
        it.per = per;
        it.tag = tag;
        wave_q.push_back(it);
        pending++;
        wait (pending == 0);
    endtask

    // Monitor side of the scoreboard
    initial begin
        forever begin
            wait (pending != 0);
            mon_item = wave_q[0];
            measure(mon_item.ch, mon_hi, mon_per);
            check($sformatf("%s high cycles ch%0d", mon_item.tag, mon_item.ch), 32'(mon_hi), 32'(mon_item.hi));
            check($sformatf("%s period cycles ch%0d", mon_item.tag, mon_item.ch), 32'(mon_per), 32'(mon_item.per));
            void'(wave_q.pop_front());
            pending--;
        end
    end

    task automatic count_low(input int ch, input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm[ch] !== 1'b1) lows++;
        end
    endtask

    task automatic count_high(input int ch, input int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm[ch] !== 1'b0) highs++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        int bad_old;
        int bad_new;
        logic ex;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 outputs during reset", 32'(pwm), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", 32'(pwm), 32'h0);
        rd(12'h000, 32'h0, "R1 gate register after reset");
        rd(12'h03C, 32'h0, "R1 ch0 period after reset");

        // Channel 0: k=0, W=9, T=3
        wr(12'h010, 32'h0000_8000);
        wr(12'h03C, 32'd9);
        wr(12'h040, 32'd3);
        rd(12'h010, 32'h0000_8000, "R4 ch0 control readback");
        rd(12'h03C, 32'd9, "R3 ch0 period readback");
        rd(12'h040, 32'd3, "R3 ch0 threshold readback");

        // Channel 1 bank at 0x50: field masking
        wr(12'h050, 32'hFFFF_FFFF);
        rd(12'h050, 32'h0000_8007, "R4 ch1 control reserved bits");
        wr(12'h07C, 32'h0000_FFFF);
        rd(12'h07C, 32'h0000_1FFF, "R3 ch1 period 13-bit field");
        wr(12'h080, 32'hFFFF_E003);
        rd(12'h080, 32'h0000_0003, "R3 ch1 threshold 13-bit field");
        wr(12'h050, 32'h0000_8001);
        wr(12'h07C, 32'd4);
        wr(12'h080, 32'd1);

        // Channel 2 bank at 0x90: T above W
        wr(12'h090, 32'h0000_8000);
        wr(12'h0BC, 32'd5);
        wr(12'h0C0, 32'd7);

        check("R8 outputs low while gated off", 32'(pwm), 32'h0);
        wr(12'h000, 32'h1);
        check("R8 ch0 high right after enable", 32'(pwm), 32'h1);
        expect_wave(0, 4, 10, "R5 R6 k0");

        wr(12'h010, 32'h0000_8002);
        expect_wave(0, 16, 40, "R5 R6 k2");
        wr(12'h010, 32'h0000_8007);
        expect_wave(0, 512, 1280, "R5 R6 k7");
        wr(12'h010, 32'h0000_8000);
        expect_wave(0, 4, 10, "R9 k0 restored");

        wr(12'h000, 32'h3);
        expect_wave(1, 4, 10, "R5 R6 R11 ch1 k1");
        expect_wave(0, 4, 10, "R11 ch0 unaffected by ch1");

        wr(12'h000, 32'h7);
        count_low(2, 30, cnt);
        check("R7 ch2 T above W low samples", 32'(cnt), 32'h0);
        wr(12'h0C0, 32'd5);
        repeat (8) @(negedge clk);
        count_low(2, 30, cnt);
        check("R7 ch2 T equal W low samples", 32'(cnt), 32'h0);

        // R9: rewrite period and threshold in the first cycle of a period
        @(negedge clk);
        while (pwm[0] !== 1'b0) @(negedge clk);
        while (pwm[0] !== 1'b1) @(negedge clk);
        addr  = 12'h03C;
        wdata = 32'd19;
        we    = 1'b1;
        samp[0] = pwm[0];
        for (int i = 1; i < 32; i++) begin
            @(negedge clk);
            samp[i] = pwm[0];
            if (i == 1) begin
                addr  = 12'h040;
                wdata = 32'd9;
            end
            if (i == 2) we = 1'b0;
        end
        bad_old = 0;
        bad_new = 0;
        for (int i = 0; i < 32; i++) begin
            ex = (i < 4) ? 1'b1 : (i < 10) ? 1'b0 : (i < 20) ? 1'b1 : (i < 30) ? 1'b0 : 1'b1;
            if (samp[i] !== ex) begin
                if (i < 10) bad_old++;
                else bad_new++;
            end
        end
        check("R9 current period kept old shape (bad samples)", 32'(bad_old), 32'h0);
        check("R9 next period uses new values (bad samples)", 32'(bad_new), 32'h0);

        // Disable ch0 only
        wr(12'h000, 32'h6);
        check("R8 ch0 low after disable", 32'(pwm[0]), 32'h0);
        count_high(0, 25, cnt);
        check("R8 ch0 stays low while disabled", 32'(cnt), 32'h0);
        expect_wave(1, 4, 10, "R11 ch1 unaffected by ch0 disable");
        wr(12'h000, 32'h7);
        check("R8 ch0 high after re-enable", 32'(pwm[0]), 32'h1);
        expect_wave(0, 10, 20, "R5 R6 ch0 new settings");

        // Gate register masking
        wr(12'h000, 32'hFF);
        rd(12'h000, 32'h7, "R2 gate bits above channel count");

        // Unmapped space
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, 32'h0, "R10 gap offset read");
        wr(12'h11C, 32'h55);
        rd(12'h11C, 32'h0, "R10 bank beyond channel count");
        wr(12'h014, 32'h1234);
        rd(12'h014, 32'h0, "R10 unused bank offset read");
        rd(12'h03C, 32'd19, "R10 ch0 period untouched by stray writes");
        rd(12'h050, 32'h0000_8001, "R10 ch1 control untouched by stray writes");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule